// File: doc/BRIEF.md
# Smart Card Reset Release Sequencer

This block produces the active-low reset level for a smart card. It watches a supply-good flag, a firmware hold request and an ETU tick, and decides when the card may leave reset. After the supply becomes good, and after firmware drops its hold request, the block keeps the card in reset for a programmed number of ETUs before it lets the pin go high. A request that is already raised before power arrives keeps a freshly powered card in reset until firmware removes it.

The delay is an 8-bit ETU count. Software normally programs it with a reset value of 0x70. The count is captured when a countdown starts. Losing the supply, or raising the hold request again, aborts any countdown and drives the pin low. When the pin rises, the block emits a one-cycle release pulse that a downstream timer can use to start its first-character timeout.

Top module: `cardResetSeq`

## Requirements
- R1: While the block reset `rstN` is low, and in the first cycle after it, `cardRstN` and `releasePulse` are 0.
- R2: When `supplyOk` is sampled 0 at a clock edge, `cardRstN` is 0 after that edge, whatever state the block was in.
- R3: When `supplyOk` is 1, `holdReq` is 0 and `delayEtu` is 0, a card that is held low rises to `cardRstN` = 1 at the first edge where these inputs are sampled.
- R4: With a non-zero `delayEtu` = N, the countdown starts at the edge where release becomes allowed. `cardRstN` rises at the edge that samples the Nth `etuTick` = 1 after that start.
- R5: When `holdReq` is sampled 1 while `supplyOk` is 1, `cardRstN` is 0 after that edge.
- R6: If `holdReq` is already 1 when `supplyOk` rises, the pin stays 0 through power-up and any number of ticks. It is released only after `holdReq` clears and the delay then elapses.
- R7: Raising `holdReq` during a countdown aborts it. A later clear restarts the full delay.
- R8: `delayEtu` is captured when a countdown starts. Changing it during the countdown does not change the release cycle.
- R9: `releasePulse` is 1 for exactly the one cycle in which `cardRstN` first reads 1 after having been 0, and is 0 otherwise.
- R10: `etuTick` has no effect while the pin is already high or while the block waits on supply or on a hold request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| supplyOk | input | 1 | Card supply is within range |
| holdReq | input | 1 | Firmware request to keep or put the card in reset |
| delayEtu | input | DELAY_W | Release delay in ETUs |
| etuTick | input | 1 | One-cycle strobe per elapsed ETU |
| cardRstN | output | 1 | Card reset pin level, 0 = card in reset |
| releasePulse | output | 1 | One-cycle strobe when the card leaves reset |

## Verification
The bench builds the block with the default DELAY_W of 8. This makes the full delay range reachable: the directed runs cover the 0x70 power-on value and the 255 ceiling, and the random runs use small delays so that many complete countdowns, aborts and supply drops fit into the run. Random ticks arrive on about two cycles in five. Because of this, the countdown start, the last tick and mid-count hold or delay changes fall at varied offsets.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_COUNT  = 2'd2,
    ST_ACTIVE = 2'd3
  } crsState_e;

  typedef struct packed {
    logic load;
    logic dec;
  } crsStrobe_t;
endpackage

// File: rtl/crsCount.sv
module crsCount
  import crs_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  crsStrobe_t         strobe,
  input  logic [DELAY_W-1:0] delayEtu,
  output logic               delayZero,
  output logic               cntOne
);
  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] remaining;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (strobe.load) begin
      remaining <= delayEtu;
    end else if (strobe.dec) begin
      remaining <= remaining - ONE;
    end
  end

  assign delayZero = (delayEtu == '0);
  assign cntOne    = (remaining == ONE);

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec && !strobe.load |=> remaining == $past(remaining) - ONE) else $error("dec step"); // R4

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> remaining == $past(delayEtu)) else $error("load capture"); // R8

  AST_NO_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> remaining > ONE) else $error("dec underflow"); // R4
endmodule

// File: rtl/crsCtrl.sv
module crsCtrl
  import crs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       holdReq,
  input  logic       etuTick,
  input  logic       delayZero,
  input  logic       cntOne,
  output crsStrobe_t strobe,
  output logic       pinHigh,
  output logic       releasePulse
);
  crsState_e state, nextState;
  logic      pulseQ;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_OFF, ST_HOLD: begin
        if (holdReq) begin
          nextState = ST_HOLD;
        end else if (delayZero) begin
          nextState = ST_ACTIVE;
        end else begin
          nextState   = ST_COUNT;
          strobe.load = 1'b1;
        end
      end
      ST_COUNT: begin
        if (holdReq) begin
          nextState = ST_HOLD;
        end else if (etuTick) begin
          if (cntOne) nextState = ST_ACTIVE;
          else        strobe.dec = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (holdReq) nextState = ST_HOLD;
      end
      default: nextState = ST_OFF;
    endcase
    if (!supplyOk) begin
      nextState = ST_OFF;
      strobe    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      pulseQ <= 1'b0;
    end else begin
      state  <= nextState;
      pulseQ <= (nextState == ST_ACTIVE) && (state != ST_ACTIVE);
    end
  end

  assign pinHigh      = (state == ST_ACTIVE);
  assign releasePulse = pulseQ;

  AST_SUPPLY_LOSS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !pinHigh) else $error("supply loss"); // R2

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |=> !pinHigh) else $error("hold"); // R5

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    releasePulse |-> pinHigh && !$past(pinHigh)) else $error("pulse without rise"); // R9

  AST_RISE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pinHigh && !$past(pinHigh) |-> releasePulse) else $error("rise without pulse"); // R9

  AST_ZERO_DELAY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    supplyOk && !holdReq && delayZero && (state == ST_OFF || state == ST_HOLD) |=> pinHigh)
    else $error("zero delay"); // R3

  AST_NO_LOAD_AND_DEC: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.dec)) else $error("strobe clash"); // R4
endmodule

// File: rtl/cardResetSeq.sv
module cardResetSeq
  import crs_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supplyOk,
  input  logic               holdReq,
  input  logic [DELAY_W-1:0] delayEtu,
  input  logic               etuTick,
  output logic               cardRstN,
  output logic               releasePulse
);
  crsStrobe_t strobe;
  logic       delayZero;
  logic       cntOne;

  crsCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supplyOk     (supplyOk),
    .holdReq      (holdReq),
    .etuTick      (etuTick),
    .delayZero    (delayZero),
    .cntOne       (cntOne),
    .strobe       (strobe),
    .pinHigh      (cardRstN),
    .releasePulse (releasePulse)
  );

  crsCount #(.DELAY_W(DELAY_W)) u_count (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .delayEtu  (delayEtu),
    .delayZero (delayZero),
    .cntOne    (cntOne)
  );
endmodule

// File: tb/cardResetSeq_bench.sv
module cardResetSeq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       supplyOk = 1'b0;
  logic       holdReq = 1'b0;
  logic [7:0] delayEtu = 8'h70;
  logic       etuTick = 1'b0;
  logic       cardRstN;
  logic       releasePulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model: 0 off, 1 hold, 2 counting, 3 released
  int         mSt = 0;
  logic [7:0] mCnt = '0;
  logic       expPin = 1'b0;
  logic       expPulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cardResetSeq u_cardResetSeq (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .holdReq(holdReq),
    .delayEtu(delayEtu), .etuTick(etuTick),
    .cardRstN(cardRstN), .releasePulse(releasePulse)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string modelStep(input logic s, input logic h, input logic t, input logic [7:0] d);
    logic  wasHigh;
    string tag;
    wasHigh = (mSt == 3);
    tag = "R10";
    if (!s) begin
      mSt = 0; tag = "R2";
    end else if (mSt == 0 || mSt == 1) begin
      if (h) begin mSt = 1; tag = "R5"; end
      else if (d == 0) begin mSt = 3; tag = "R3"; end
      else begin mSt = 2; mCnt = d; tag = "R4"; end
    end else if (mSt == 2) begin
      if (h) begin mSt = 1; tag = "R7"; end
      else if (t) begin
        tag = "R4";
        if (mCnt == 1) mSt = 3;
        else mCnt = mCnt - 1;
      end
    end else if (h) begin
      mSt = 1; tag = "R5";
    end
    expPin   = (mSt == 3);
    expPulse = expPin && !wasHigh;
    return tag;
  endfunction

  task automatic cycle(input logic s, input logic h, input logic t, input logic [7:0] d, input string force_tag);
    string tag;
    supplyOk = s; holdReq = h; etuTick = t; delayEtu = d;
    tag = modelStep(s, h, t, d);
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    @(negedge clk);
    check(cardRstN, expPin, tag, "cardRstN");
    check(releasePulse, expPulse, "R9", "releasePulse");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s, h, t;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cardRstN, 1'b0, "R1", "cardRstN in reset");
    check(releasePulse, 1'b0, "R1", "releasePulse in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(cardRstN, 1'b0, "R1", "cardRstN after reset");

    // R3: zero delay, immediate release
    cycle(1, 0, 0, 8'd0, "R3");
    cycle(1, 0, 1, 8'd0, "R10");
    cycle(0, 0, 0, 8'd0, "R2");

    // R4: power-on delay 0x70, ticks every cycle
    for (int i = 0; i < 114; i++) cycle(1, 0, 1, 8'h70, "R4");
    check(cardRstN, 1'b1, "R4", "released after 0x70 ticks");
    cycle(0, 0, 1, 8'h70, "R2");

    // R4: maximal delay with sparse ticks
    for (int i = 0; i < 600; i++) cycle(1, 0, (i % 2) == 1, 8'hFF, "R4");

    // R6: hold through power-up
    cycle(0, 1, 0, 8'd3, "R2");
    for (int i = 0; i < 20; i++) cycle(1, 1, 1, 8'd3, "R6");
    for (int i = 0; i < 5; i++) cycle(1, 0, 1, 8'd3, "R6");
    check(cardRstN, 1'b1, "R6", "released after hold clear");

    // R7: abort mid countdown, then full restart
    for (int i = 0; i < 3; i++) cycle(1, 1, 1, 8'd6, "R5");
    for (int i = 0; i < 3; i++) cycle(1, 0, 1, 8'd6, "R7");
    cycle(1, 1, 1, 8'd6, "R7");
    for (int i = 0; i < 8; i++) cycle(1, 0, 1, 8'd6, "R7");

    // R8: delay change mid countdown
    cycle(1, 1, 0, 8'd5, "R5");
    cycle(1, 0, 0, 8'd5, "R8");
    for (int i = 0; i < 2; i++) cycle(1, 0, 1, 8'd50, "R8");
    for (int i = 0; i < 4; i++) cycle(1, 0, 1, 8'd1, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      s = ($urandom_range(99) >= 3);
      h = ($urandom_range(99) < 8) ? ~holdReq : holdReq;
      t = ($urandom_range(99) < 40);
      d = ($urandom_range(9) == 0) ? delayEtu : 8'($urandom_range(5));
      if ($urandom_range(99) < 85) d = delayEtu;
      cycle(s, h, t, d, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule